// File: doc/BRIEF.md
# Active-Low Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines from peripherals. It shows them to a host processor through three 32-bit registers on a simple single-strobe bus. Every status and mask bit uses inverted polarity: a 0 marks a source that is pending or enabled, and a 1 marks one that is idle or disabled.

The raw view lists every asserted source, whether or not it is masked. The request view is the bitwise OR of the raw view and the mask, so it shows only the enabled sources that are asserted. A request view of all ones means nothing is asking for service. The block drives one combined interrupt line to the processor. Next to that line it presents the index of the lowest-numbered active request and a valid flag, so the handler can dispatch without scanning the word.

Sources are level-triggered and need no acknowledge. Each pin is active-high, goes through a two-flop synchronizer, and is then inverted into the register convention. Slots 0 and 1 are reserved for the controller's own functions and never produce a request.

Top module: `low_lvl_intc`

## Requirements
- R1: After reset the mask reads 0xFFFFFFFF, the read data output is 0xFFFFFFFF, and irq_o and irq_id_vld are both 0.
- R2: A write to byte offset 0x004 stores the full 32-bit word in the mask. A read of 0x004 returns that word.
- R3: The raw view at offset 0x008 has bit n equal to 0 while source n is high and 1 while it is low, for n from 2 to 31, whatever the mask holds.
- R4: The request view at offset 0x000 equals the raw view ORed with the mask, so a 1 in mask bit n hides source n.
- R5: Bits 0 and 1 read as 1 in the raw and request views whatever src_i[1:0] and the mask hold, and irq_id is never 0 or 1 while irq_id_vld is 1.
- R6: Writes to offsets 0x000 and 0x008 are ignored: the raw and request views read afterwards still follow the sources and the mask.
- R7: irq_o is 1 exactly when the request view holds at least one 0. It stays at 1 for as long as an enabled source stays high, with no acknowledge, and falls once that source goes low.
- R8: irq_id gives the position of the lowest 0 in the request view. irq_id_vld equals irq_o, and irq_id is 0 when irq_id_vld is 0.
- R9: A change on a source pin shows on irq_o and in the registers after the second rising clock edge, and not after the first.
- R10: A read of any offset other than 0x000, 0x004 or 0x008 returns 0xFFFFFFFF.
- R11: Read data is registered. bus_rdata takes the addressed value on the clock edge that samples the read strobe, and it holds that value through idle cycles and write cycles until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Active-high peripheral interrupt levels, bit n = source n |
| bus_cs | input | 1 | Single-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read, qualified by bus_cs |
| bus_addr | input | 12 | Byte offset within the controller window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt to the processor, active high |
| irq_id | output | 5 | Index of the lowest active request |
| irq_id_vld | output | 1 | irq_id is meaningful |

## Verification
Results become due at three different points. A change on a source pin is due after the second rising edge that follows it, and the bench samples one edge early to show that the change has not yet arrived. A mask write takes effect on irq_o and irq_id right after the edge that samples the write strobe. Read data is due on the negative edge that follows the edge that samples the read strobe. The bench drives every input on a falling edge and samples only on falling edges, counting edges explicitly, so each check lands in the cycle where its result is first due.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // Register selection derived from the byte offset
   typedef enum logic [1:0] {
      SEL_REQ  = 2'd0,
      SEL_MASK = 2'd1,
      SEL_PEND = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int unsigned OFS_REQ  = 'h000;
   localparam int unsigned OFS_MASK = 'h004;
   localparam int unsigned OFS_PEND = 'h008;

   function automatic reg_sel_e decode_ofs(input int unsigned ofs);
      reg_sel_e s;
      case (ofs)
         OFS_REQ:  s = SEL_REQ;
         OFS_MASK: s = SEL_MASK;
         OFS_PEND: s = SEL_PEND;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("intc_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d_i;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/intc_regs.sv
module intc_regs
   import intc_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] pend_n_i,
   input  logic [DATA_W-1:0] req_n_i,
   output logic [DATA_W-1:0] mask_n_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("intc_regs: ADDR_W must cover offset 0x008");
   end

   reg_sel_e          sel;
   logic              wr_en;
   logic              rd_en;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      sel   = decode_ofs(int'(addr_i));
      wr_en = cs_i & we_i;
      rd_en = cs_i & ~we_i;
   end

   // Mask storage: only the mask offset is writable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_n_o <= ALL_ONES;
      end else if (wr_en && sel == SEL_MASK) begin
         mask_n_o <= wdata_i;
      end
   end

   always_comb begin
      case (sel)
         SEL_REQ:  rd_mux = req_n_i;
         SEL_MASK: rd_mux = mask_n_o;
         SEL_PEND: rd_mux = pend_n_i;
         default:  rd_mux = ALL_ONES;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_o <= ALL_ONES;
      end else if (rd_en) begin
         rdata_o <= rd_mux;
      end
   end
endmodule

// File: rtl/intc_prio.sv
module intc_prio #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned ID_W  = 5
) (
   input  logic [WIDTH-1:0] req_n_i,
   output logic [ID_W-1:0]  id_o,
   output logic             vld_o
);
   if ((1 << ID_W) < WIDTH) begin : g_bad_id
      $error("intc_prio: ID_W too narrow for WIDTH");
   end

   // Scan from the top down so the lowest zero is the last one written
   always_comb begin
      id_o  = '0;
      vld_o = 1'b0;
      for (int i = WIDTH-1; i >= 0; i--) begin
         if (!req_n_i[i]) begin
            id_o  = ID_W'(i);
            vld_o = 1'b1;
         end
      end
   end
endmodule

// File: rtl/low_lvl_intc.sv
module low_lvl_intc #(
   parameter int unsigned N_SRC   = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned RSVD    = 2,
   parameter int unsigned SYNC_ST = 2,
   parameter int unsigned ID_W    = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              bus_cs,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic [ID_W-1:0]   irq_id,
   output logic              irq_id_vld
);
   if (N_SRC > DATA_W) begin : g_bad_src
      $error("low_lvl_intc: N_SRC exceeds DATA_W");
   end
   if (RSVD >= N_SRC) begin : g_bad_rsvd
      $error("low_lvl_intc: RSVD leaves no usable source");
   end

   logic [N_SRC-1:0]  src_s;
   logic [DATA_W-1:0] pend_n;
   logic [DATA_W-1:0] mask_n;
   logic [DATA_W-1:0] req_n;

   intc_sync #(.WIDTH(N_SRC), .STAGES(SYNC_ST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (src_s)
   );

   // Reserved and absent slots read as not pending
   for (genvar i = 0; i < DATA_W; i++) begin : g_pend
      if (i < RSVD || i >= N_SRC) begin : g_idle
         assign pend_n[i] = 1'b1;
      end else begin : g_live
         assign pend_n[i] = ~src_s[i];
      end
   end

   assign req_n = pend_n | mask_n;
   assign irq_o = ~&req_n;

   intc_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_i     (bus_cs),
      .we_i     (bus_we),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata),
      .pend_n_i (pend_n),
      .req_n_i  (req_n),
      .mask_n_o (mask_n),
      .rdata_o  (bus_rdata)
   );

   intc_prio #(.WIDTH(DATA_W), .ID_W(ID_W)) u_prio (
      .req_n_i (req_n),
      .id_o    (irq_id),
      .vld_o   (irq_id_vld)
   );
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
   parameter int unsigned N_SRC  = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned RSVD   = 2,
   parameter int unsigned ID_W   = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  src_i,
   input logic              bus_cs,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq_o,
   input logic [ID_W-1:0]   irq_id,
   input logic              irq_id_vld
);
   AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && !irq_id_vld)); // R1

   AST_ID_IS_LIVE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      irq_id_vld |-> ((($past(src_i, 2) >> irq_id) & 1) != 0)); // R3

   AST_ID_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_id_vld |-> (irq_id >= ID_W'(RSVD))); // R5

   AST_VLD_EQ_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_id_vld == irq_o); // R8

   AST_ID_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_id_vld |-> (irq_id == '0)); // R8

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_cs && !bus_we) |=> $stable(bus_rdata)); // R11
endmodule

bind low_lvl_intc intc_chk #(
   .N_SRC(N_SRC), .DATA_W(DATA_W), .RSVD(RSVD), .ID_W(ID_W)
) u_intc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_i      (src_i),
   .bus_cs     (bus_cs),
   .bus_we     (bus_we),
   .bus_rdata  (bus_rdata),
   .irq_o      (irq_o),
   .irq_id     (irq_id),
   .irq_id_vld (irq_id_vld)
);

// File: tb/test_low_lvl_intc.sv
module test_low_lvl_intc;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_i = '0;
   logic        bus_cs = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o;
   logic [4:0]  irq_id;
   logic        irq_id_vld;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   low_lvl_intc i_low_lvl_intc (
      .clk(clk), .rst_n(rst_n), .src_i(src_i),
      .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o), .irq_id(irq_id), .irq_id_vld(irq_id_vld)
   );

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] mask;
      logic [31:0] req;
      logic        irq;
      logic [4:0]  id;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{src:32'h0000_0010, mask:32'hFFFF_FFEF, req:32'hFFFF_FFEF, irq:1'b1, id:5'd4},
      '{src:32'h0000_0010, mask:32'hFFFF_FFFF, req:32'hFFFF_FFFF, irq:1'b0, id:5'd0},
      '{src:32'h8000_0100, mask:32'h7FFF_FFFF, req:32'h7FFF_FFFF, irq:1'b1, id:5'd31},
      '{src:32'h8000_0100, mask:32'h0000_0000, req:32'h7FFF_FEFF, irq:1'b1, id:5'd8},
      '{src:32'h0000_0003, mask:32'h0000_0000, req:32'hFFFF_FFFF, irq:1'b0, id:5'd0},
      '{src:32'hFFFF_FFFF, mask:32'hFFFF_FFF0, req:32'hFFFF_FFF3, irq:1'b1, id:5'd2},
      '{src:32'h0000_0F00, mask:32'hFFFF_F7FF, req:32'hFFFF_F7FF, irq:1'b1, id:5'd11}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_cs = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [31:0] pend_of(input logic [31:0] s);
      return ~s | 32'h3;
   endfunction

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=expired expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d;
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", "rdata at reset", bus_rdata, 32'hFFFF_FFFF);
      check("R1", "irq_o at reset", {31'd0, irq_o}, 32'd0);
      check("R1", "vld at reset", {31'd0, irq_id_vld}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      rd(12'h004, d);
      check("R1", "mask after reset", d, 32'hFFFF_FFFF);

      // R2 mask write and readback
      wr(12'h004, 32'hA5A5_0F0F);
      rd(12'h004, d);
      check("R2", "mask readback", d, 32'hA5A5_0F0F);
      wr(12'h004, 32'hFFFF_FFFF);

      // Vector table: R3 R4 R5 R7 R8
      for (int v = 0; v < NV; v++) begin
         wr(12'h004, VECS[v].mask);
         @(negedge clk);
         src_i = VECS[v].src;
         @(negedge clk);
         @(negedge clk);
         check("R7", $sformatf("vec%0d irq_o", v), {31'd0, irq_o}, {31'd0, VECS[v].irq});
         check("R8", $sformatf("vec%0d irq_id", v), {27'd0, irq_id}, {27'd0, VECS[v].id});
         check("R8", $sformatf("vec%0d vld", v), {31'd0, irq_id_vld}, {31'd0, VECS[v].irq});
         rd(12'h000, d);
         check("R4", $sformatf("vec%0d request", v), d, VECS[v].req);
         rd(12'h008, d);
         check("R3", $sformatf("vec%0d pending", v), d, pend_of(VECS[v].src));
         check("R5", $sformatf("vec%0d reserved bits", v), {30'd0, d[1:0]}, 32'd3);
      end

      // R9 latency: visible after second edge, not first
      wr(12'h004, 32'h0000_0000);
      @(negedge clk);
      src_i = '0;
      repeat (3) @(negedge clk);
      src_i = 32'h0000_0040;
      @(negedge clk);
      check("R9", "irq after one edge", {31'd0, irq_o}, 32'd0);
      @(negedge clk);
      check("R9", "irq after two edges", {31'd0, irq_o}, 32'd1);
      check("R9", "id after two edges", {27'd0, irq_id}, 32'd6);

      // R7 level behaviour: holds without acknowledge, drops with source
      repeat (20) @(negedge clk);
      check("R7", "irq held with source high", {31'd0, irq_o}, 32'd1);
      src_i = '0;
      @(negedge clk);
      check("R7", "irq one edge after drop", {31'd0, irq_o}, 32'd1);
      @(negedge clk);
      check("R7", "irq after source drop", {31'd0, irq_o}, 32'd0);

      // R6 writes to read-only views ignored
      src_i = 32'h0000_2000;
      repeat (2) @(negedge clk);
      wr(12'h000, 32'h0000_0000);
      wr(12'h008, 32'h0000_0000);
      rd(12'h008, d);
      check("R6", "pending after write", d, 32'hFFFF_DFFF);
      rd(12'h000, d);
      check("R6", "request after write", d, 32'hFFFF_DFFF);
      rd(12'h004, d);
      check("R6", "mask untouched", d, 32'h0000_0000);
      wr(12'h004, 32'hFFFF_FFFF);
      rd(12'h000, d);
      check("R6", "request follows mask", d, 32'hFFFF_FFFF);

      // R10 unmapped offsets
      wr(12'h004, 32'h0000_0000);
      rd(12'h00C, d);
      check("R10", "offset 0x00C", d, 32'hFFFF_FFFF);
      rd(12'h104, d);
      check("R10", "offset 0x104", d, 32'hFFFF_FFFF);

      // R11 registered read data holds
      rd(12'h008, held);
      check("R11", "read value", held, 32'hFFFF_DFFF);
      src_i = '0;
      repeat (4) @(negedge clk);
      check("R11", "hold over idle", bus_rdata, held);
      wr(12'h004, 32'h1234_5678);
      check("R11", "hold over write", bus_rdata, held);
      rd(12'h008, d);
      check("R11", "new read updates", d, 32'hFFFF_FFFF);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule